// File: doc/BRIEF.md
# Dithered Oscillator Tuning DAC Code Generator

This block turns a fine oscillator tuning word into a 16-bit DAC code. The tuning word has 8 more fractional bits than the DAC can resolve. Its upper 16 bits give a base code. On each update strobe, a first-order sigma-delta accumulator adds the fractional byte. When the addition carries, the block outputs the code one step above the base. Otherwise it outputs the base code. Over time the average DAC code matches the fine setting, which gives 2^24 effective steps instead of one rounded code.

A holdover input freezes the latched tuning word while the reference pulse is missing. The last correction keeps being applied and the dithering keeps running. The loop filter that computes the word, the DAC's serial link and the analog stage all lie outside this block.

Top module: `dac_dither`

## Requirements
- R1: A synchronous active-high reset sets the DAC code to 0x8000, clears the fractional accumulator, and sets the latched word to integer 0x8000 with a fraction of 0.
- R2: The DAC code changes only on a clock edge where the strobe is high.
- R3: After a strobe, the DAC code equals either the selected base code (tune_word bits 23:8) or that base plus one.
- R4: With a constant word of fraction F (bits 7:0), any 256 consecutive strobes give exactly F outputs of base plus one.
- R5: On each strobe the accumulator becomes (acc + F) mod 256. The code is base plus one exactly when that sum reaches 256.
- R6: When the base code is 0xFFFF, the output stays 0xFFFF and never wraps to zero.
- R7: While holdover is high, strobes use the previously latched word, tune_word is ignored, and dithering continues.
- R8: The strobe following the clearing of holdover latches and uses the current tune_word.
- R9: Changes to tune_word between strobes have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Update tick: one dither step per high cycle |
| holdover | input | 1 | High while the reference is lost: freezes the latched word |
| tune_word | input | 24 | Tuning word: integer bits 23:8, fractional bits 7:0 |
| dac_code | output | 16 | DAC code |

## Verification
The bench sweeps all 256 fractions, with 256 strobes each, and checks both the count of up-steps and the position of each carry.

- A design with an off-by-one carry, or an accumulator that is not truncated, would miss the exact count of up-steps.
- A design without saturation would wrap 0xFFFF to 0x0000 at the top base.
- A design that loads words during holdover, or between strobes, would jump to the new base early.
- A design that does not resume after holdover would remain stuck on the old base.
- A reset that leaves the accumulator set would shift the carry phase after reset.

// File: rtl/dac_dither.sv
module dac_dither #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      strobe,
  input  logic                      holdover,
  input  logic [INT_W+FRAC_W-1:0]   tune_word,
  output logic [INT_W-1:0]          dac_code
);
  localparam int TW_W = INT_W + FRAC_W;
  localparam logic [INT_W-1:0] MID_CODE = INT_W'(1) << (INT_W - 1);

  logic [TW_W-1:0]   word_q;
  logic [TW_W-1:0]   word_sel;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [INT_W-1:0]  base;
  logic [FRAC_W-1:0] frac;
  logic              at_top;

  assign word_sel = holdover ? word_q : tune_word;
  assign base     = word_sel[TW_W-1:FRAC_W];
  assign frac     = word_sel[FRAC_W-1:0];
  assign sum      = {1'b0, acc_q} + {1'b0, frac};
  assign at_top   = &base;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      word_q   <= {MID_CODE, {FRAC_W{1'b0}}};
      dac_code <= MID_CODE;
    end else if (strobe) begin
      acc_q <= sum[FRAC_W-1:0];
      if (!holdover) word_q <= tune_word;
      dac_code <= (sum[FRAC_W] && !at_top) ? base + INT_W'(1) : base;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (dac_code == MID_CODE && acc_q == '0));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(dac_code));

  assert_adjacent_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (dac_code == $past(base) || dac_code == $past(base) + INT_W'(1)));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe && at_top) |=> (&dac_code));

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (rst)
    holdover |=> $stable(word_q));
endmodule

// File: tb/dac_dither_tb.sv
module dac_dither_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic        holdover = 1'b0;
  logic [23:0] tune_word = 24'h0;
  logic [15:0] dac_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [23:0] m_word;
  logic [7:0]  m_acc;

  dac_dither u_dut (.clk(clk), .rst(rst), .strobe(strobe), .holdover(holdover),
                    .tune_word(tune_word), .dac_code(dac_code));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; strobe = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    m_word = 24'h800000; m_acc = 8'h0;
  endtask

  task automatic step(input logic [23:0] w, input logic h, input string req,
                      output logic up);
    logic [23:0] sel;
    logic [8:0]  s;
    logic [15:0] exp;
    @(negedge clk); strobe = 1'b1; holdover = h; tune_word = w;
    sel = h ? m_word : w;
    if (!h) m_word = w;
    s = {1'b0, m_acc} + {1'b0, sel[7:0]};
    m_acc = s[7:0];
    up = s[8] && (sel[23:8] != 16'hFFFF);
    exp = up ? sel[23:8] + 16'd1 : sel[23:8];
    @(posedge clk); #1;
    check(req, dac_code, exp);
    @(negedge clk); strobe = 1'b0;
  endtask

  initial begin
    logic u;
    int ups;
    do_reset();
    check("R1 reset code", dac_code, 16'h8000);
    holdover = 1'b1;
    for (int i = 0; i < 4; i++) step(24'h123456, 1'b1, "R1 held mid-scale", u);
    holdover = 1'b0;

    for (int f = 0; f < 256; f++) begin
      ups = 0;
      for (int n = 0; n < 256; n++) begin
        step({16'h4A21, 8'(f)}, 1'b0, "R5 carry sequence", u);
        if (u) ups++;
      end
      check("R4 up-step count", 16'(ups), 16'(f));
    end

    for (int f = 1; f < 256; f += 37)
      for (int n = 0; n < 20; n++) step({16'hFFFF, 8'(f)}, 1'b0, "R6 no wrap at top", u);
    for (int n = 0; n < 20; n++) step({16'h0000, 8'hC3}, 1'b0, "R3 bottom base", u);
    for (int n = 0; n < 20; n++) step({16'hFFFE, 8'h81}, 1'b0, "R3 near top", u);

    step(24'h300040, 1'b0, "R7 preload", u);
    for (int n = 0; n < 12; n++) step(24'h9000F0, 1'b1, "R7 holdover keeps word", u);
    step(24'h9000F0, 1'b0, "R8 resume load", u);
    check("R8 new base", dac_code & 16'hFFFE, 16'h9000);

    begin
      logic [15:0] held;
      held = dac_code;
      for (int n = 0; n < 10; n++) begin
        @(negedge clk); tune_word = 24'h00FF00 + 24'(n * 24'h1111);
        @(posedge clk); #1;
        check("R9 no change between strobes", dac_code, held);
        check("R2 quiet without strobe", dac_code, held);
      end
    end

    for (int n = 0; n < 5; n++) step(24'h123480, 1'b0, "R5 before reset", u);
    do_reset();
    check("R1 code after reset", dac_code, 16'h8000);
    step(24'h200080, 1'b0, "R1 acc cleared step1", u);
    check("R1 acc cleared first", dac_code, 16'h2000);
    step(24'h200080, 1'b0, "R1 acc cleared step2", u);
    check("R1 acc cleared second", dac_code, 16'h2001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule